// File: doc/BRIEF.md
# Split-Transaction Bus Tenure Tracker

This block sits between a requester and a processor system bus whose address and data phases run on separate buses. A requester hands it one transfer at a time over a valid/ready channel: an address, a byte count, a burst flag and a tag. The block asks an external arbiter for bus mastership and drives an address tenure once it holds the grant. After the address is acknowledged, the transfer waits in a small in-order list until its data beats are acknowledged. A new address tenure may start while earlier transfers are still waiting for data, and at most two transfers are ever in flight.

A transfer is either a single beat of 1, 2, 3, 4 or 8 bytes, or a four-beat burst of 32 bytes. Data acknowledges always count against the oldest transfer still waiting for data. When that transfer's last beat is acknowledged, the block pulses a completion strobe that carries the transfer's tag.

Back-pressure on the request channel works as follows. A request moves only on a clock edge where both `req_valid` and `req_ready` are high. The requester keeps the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` falls while an address tenure is in progress and while two transfers are waiting for data. The completion strobe and the bus pins are plain signals and cannot be stalled.

Top module: `bus_tenure_tracker`

## Requirements
- R1: While reset is held, `br_o`, `abus_valid` and `done_valid` are low and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no address tenure is pending and fewer than two transfers are waiting for data.
- R3: An address tenure holds `abus_valid` high, with `abus_addr`, `abus_bytes` and `abus_burst` stable, until the edge that samples `aack_i`. A burst reports a byte count of 32 whatever `req_bytes` held. A single beat reports its own byte count.
- R4: If `bg_i` is low on the accepting edge, `br_o` is high from the next cycle until an edge samples `bg_i` high. The cycle after that edge, `br_o` is low and `abus_valid` is high.
- R5: If `bg_i` is high on the accepting edge, the address tenure starts in the next cycle and `br_o` never rises (bus parking).
- R6: While two transfers are waiting for data, `br_o` and `req_ready` stay low, even when `req_valid` is high. When one of them retires, `req_ready` returns in the next cycle.
- R7: Each `dack_i` sampled high counts one beat against the oldest waiting transfer. A single beat retires on its first acknowledge and a burst on its fourth. `done_valid` is high in the cycle after the retiring edge, with that transfer's `done_tag` and `done_burst`, so completions come out in address order.
- R8: A `dack_i` sampled while no transfer is waiting for data is ignored. It produces no completion and does not advance the beat count of any later transfer.
- R9: A single-beat request whose `req_bytes` is not 1, 2, 3, 4 or 8 is taken but dropped. It raises neither `br_o` nor `abus_valid`, it never completes, and `req_ready` stays high.
- R10: An address tenure may run while an earlier transfer still waits for data. When `aack_i` and `dack_i` are sampled on the same edge, both take effect, and the beat goes to the earlier transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Transfer address |
| req_bytes | input | 4 | Byte count of a single beat (legal: 1, 2, 3, 4, 8) |
| req_burst | input | 1 | 1 = four-beat 32-byte burst |
| req_tag | input | TAGW | Requester's label, returned on completion |
| br_o | output | 1 | Bus request to the arbiter |
| bg_i | input | 1 | Bus grant from the arbiter |
| abus_valid | output | 1 | Address tenure in progress |
| abus_addr | output | AW | Address driven during the tenure |
| abus_bytes | output | 6 | Byte count driven during the tenure (32 for bursts) |
| abus_burst | output | 1 | Burst flag driven during the tenure |
| aack_i | input | 1 | Address acknowledge; ends the tenure |
| dack_i | input | 1 | Data beat acknowledge |
| done_valid | output | 1 | One-cycle completion strobe |
| done_tag | output | TAGW | Tag of the completed transfer |
| done_burst | output | 1 | Completed transfer was a burst |

## Verification
Each result is due a fixed number of cycles after its stimulus. `br_o` and `abus_valid` react one cycle after the accepting edge, or one cycle after the edge that samples the grant. `req_ready` follows the registered state, so it changes one cycle after a push or a retire. `done_valid` rises right after the edge that samples the retiring `dack_i`. Inputs are driven on the falling edge, so direct checks on the falling edge see exactly the state left by the previous rising edge. The scoreboard monitor samples 2 ns after each rising edge. It runs its own beat count for the oldest expected transfer and, on every edge, compares whether a completion is due with what `done_valid`, `done_tag` and `done_burst` show.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;

  typedef enum logic [1:0] {
    A_IDLE = 2'd0,
    A_REQ  = 2'd1,
    A_ADDR = 2'd2
  } addr_state_e;

  // single-beat byte counts the bus can carry
  function automatic logic bytes_legal(input logic [3:0] b);
    logic ok;
    case (b)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd8: ok = 1'b1;
      default:                      ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/bus_tenure_addr_ctrl.sv
module bus_tenure_addr_ctrl
  import bus_tenure_pkg::*;
#(
  parameter int AW          = 32,
  parameter int TAGW        = 4,
  parameter int SZW         = 6,
  parameter int BURST_BYTES = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_bytes,
  input  logic            req_burst,
  input  logic [TAGW-1:0] req_tag,
  input  logic            room,
  input  logic            bg_i,
  output logic            br_o,
  output logic            abus_valid,
  output logic [AW-1:0]   abus_addr,
  output logic [SZW-1:0]  abus_bytes,
  output logic            abus_burst,
  input  logic            aack_i,
  output logic            push,
  output logic [TAGW-1:0] push_tag,
  output logic            push_burst
);

  addr_state_e     state_q, state_d;
  logic [AW-1:0]   addr_q;
  logic [3:0]      bytes_q;
  logic            burst_q;
  logic [TAGW-1:0] tag_q;
  logic            accept;
  logic            legal;

  assign req_ready = (state_q == A_IDLE) && room;
  assign accept    = req_valid && req_ready;
  assign legal     = req_burst || bytes_legal(req_bytes);

  always_comb begin
    state_d = state_q;
    case (state_q)
      A_IDLE: begin
        if (accept && legal) state_d = bg_i ? A_ADDR : A_REQ;
      end
      A_REQ: begin
        if (bg_i) state_d = A_ADDR;
      end
      A_ADDR: begin
        if (aack_i) state_d = A_IDLE;
      end
      default: state_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= A_IDLE;
      addr_q  <= '0;
      bytes_q <= '0;
      burst_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        bytes_q <= req_bytes;
        burst_q <= req_burst;
        tag_q   <= req_tag;
      end
    end
  end

  assign br_o       = (state_q == A_REQ);
  assign abus_valid = (state_q == A_ADDR);
  assign abus_addr  = addr_q;
  assign abus_burst = burst_q;
  assign abus_bytes = burst_q ? SZW'(BURST_BYTES) : SZW'(bytes_q);

  assign push       = (state_q == A_ADDR) && aack_i;
  assign push_tag   = tag_q;
  assign push_burst = burst_q;

endmodule

// File: rtl/bus_tenure_data_q.sv
module bus_tenure_data_q #(
  parameter int TAGW        = 4,
  parameter int DEPTH       = 2,
  parameter int BURST_BEATS = 4,
  parameter int CW          = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [TAGW-1:0] push_tag,
  input  logic            push_burst,
  input  logic            dack_i,
  output logic [CW-1:0]   count,
  output logic            done_valid,
  output logic [TAGW-1:0] done_tag,
  output logic            done_burst
);

  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BCW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count_q;
  logic [BCW-1:0]  beat_q;
  logic [TAGW-1:0] slot_tag   [DEPTH];
  logic            slot_burst [DEPTH];
  logic            head_burst;
  logic            beat_hit;
  logic            pop;

  // one storage slot per outstanding transfer
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TAGW-1:0] tag_q;
    logic            burst_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q   <= '0;
        burst_q <= 1'b0;
      end else if (push && (wr_ptr == PW'(i))) begin
        tag_q   <= push_tag;
        burst_q <= push_burst;
      end
    end
    assign slot_tag[i]   = tag_q;
    assign slot_burst[i] = burst_q;
  end

  assign head_burst = slot_burst[rd_ptr];
  assign beat_hit   = dack_i && (count_q != '0);
  assign pop        = beat_hit && (!head_burst || (beat_q == BCW'(BURST_BEATS - 1)));

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count_q    <= '0;
      beat_q     <= '0;
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_burst <= 1'b0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (beat_hit) beat_q <= pop ? '0 : beat_q + 1'b1;
      done_valid <= pop;
      if (pop) begin
        done_tag   <= slot_tag[rd_ptr];
        done_burst <= head_burst;
      end
    end
  end

  assign count = count_q;

endmodule

// File: rtl/bus_tenure_tracker.sv
module bus_tenure_tracker #(
  parameter int AW          = 32,
  parameter int TAGW        = 4,
  parameter int MAX_OUT     = 2,
  parameter int BURST_BEATS = 4,
  parameter int BEAT_BYTES  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_bytes,
  input  logic            req_burst,
  input  logic [TAGW-1:0] req_tag,
  output logic            br_o,
  input  logic            bg_i,
  output logic            abus_valid,
  output logic [AW-1:0]   abus_addr,
  output logic [5:0]      abus_bytes,
  output logic            abus_burst,
  input  logic            aack_i,
  input  logic            dack_i,
  output logic            done_valid,
  output logic [TAGW-1:0] done_tag,
  output logic            done_burst
);

  localparam int BURST_BYTES = BURST_BEATS * BEAT_BYTES;
  localparam int SZW         = 6;
  localparam int CW          = $clog2(MAX_OUT + 1);

  logic [CW-1:0]   q_count;
  logic            room;
  logic            push;
  logic [TAGW-1:0] push_tag;
  logic            push_burst;

  assign room = (q_count < CW'(MAX_OUT));

  bus_tenure_addr_ctrl #(
    .AW(AW), .TAGW(TAGW), .SZW(SZW), .BURST_BYTES(BURST_BYTES)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes),
    .req_burst(req_burst), .req_tag(req_tag),
    .room(room), .bg_i(bg_i), .br_o(br_o),
    .abus_valid(abus_valid), .abus_addr(abus_addr),
    .abus_bytes(abus_bytes), .abus_burst(abus_burst),
    .aack_i(aack_i),
    .push(push), .push_tag(push_tag), .push_burst(push_burst)
  );

  bus_tenure_data_q #(
    .TAGW(TAGW), .DEPTH(MAX_OUT), .BURST_BEATS(BURST_BEATS), .CW(CW)
  ) u_data (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_tag(push_tag), .push_burst(push_burst),
    .dack_i(dack_i), .count(q_count),
    .done_valid(done_valid), .done_tag(done_tag), .done_burst(done_burst)
  );

endmodule

// File: rtl/bus_tenure_tracker_chk.sv
module bus_tenure_tracker_chk #(
  parameter int AW      = 32,
  parameter int MAX_OUT = 2,
  parameter int CW      = 2,
  parameter int SZW     = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           br_o,
  input logic           bg_i,
  input logic           req_ready,
  input logic           abus_valid,
  input logic [AW-1:0]  abus_addr,
  input logic [SZW-1:0] abus_bytes,
  input logic           aack_i,
  input logic           dack_i,
  input logic           done_valid,
  input logic [CW-1:0]  q_count
);

  // R6: full list blocks both the arbiter request and the request channel
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CW'(MAX_OUT)) |-> (!br_o && !req_ready));

  // R6: never more transfers waiting than allowed
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(MAX_OUT));

  // R3: tenure held stable until address acknowledge
  a_r3_tenure_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_valid && !aack_i) |=> (abus_valid && $stable(abus_addr) && $stable(abus_bytes)));

  // R4: request stays up until granted
  a_r4_br_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (br_o && !bg_i) |=> br_o);

  // R4: grant turns the request into an address tenure
  a_r4_grant_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (br_o && bg_i) |=> (!br_o && abus_valid));

  // R7: a completion always follows a sampled data acknowledge
  a_r7_done_after_dack: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(dack_i));

  // R8: nothing waiting means nothing can complete next
  a_r8_empty_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |=> !done_valid);

endmodule

bind bus_tenure_tracker bus_tenure_tracker_chk #(
  .AW(AW), .MAX_OUT(MAX_OUT), .CW(CW), .SZW(SZW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .br_o(br_o), .bg_i(bg_i),
  .req_ready(req_ready), .abus_valid(abus_valid),
  .abus_addr(abus_addr), .abus_bytes(abus_bytes),
  .aack_i(aack_i), .dack_i(dack_i),
  .done_valid(done_valid), .q_count(q_count)
);

// File: tb/bus_tenure_tracker_tb.sv
`timescale 1ns/1ps
module bus_tenure_tracker_tb;
  localparam int AW   = 32;
  localparam int TAGW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_addr = '0;
  logic [3:0]      req_bytes = '0;
  logic            req_burst = 1'b0;
  logic [TAGW-1:0] req_tag = '0;
  logic            br_o;
  logic            bg_i = 1'b0;
  logic            abus_valid;
  logic [AW-1:0]   abus_addr;
  logic [5:0]      abus_bytes;
  logic            abus_burst;
  logic            aack_i = 1'b0;
  logic            dack_i = 1'b0;
  logic            done_valid;
  logic [TAGW-1:0] done_tag;
  logic            done_burst;

  always #4 clk = ~clk;

  bus_tenure_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes),
    .req_burst(req_burst), .req_tag(req_tag),
    .br_o(br_o), .bg_i(bg_i),
    .abus_valid(abus_valid), .abus_addr(abus_addr),
    .abus_bytes(abus_bytes), .abus_burst(abus_burst),
    .aack_i(aack_i), .dack_i(dack_i),
    .done_valid(done_valid), .done_tag(done_tag), .done_burst(done_burst)
  );

  int checks = 0;
  int errors = 0;
  int dones_seen = 0;

  typedef struct {
    logic [TAGW-1:0] tag;
    logic            burst;
    int              rem;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: own beat count against the oldest expected transfer
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      logic            exp_done;
      logic [TAGW-1:0] etag;
      logic            eburst;
      string           rq;
      exp_done = 1'b0;
      etag     = '0;
      eburst   = 1'b0;
      rq       = (sb.size() == 0) ? "R8" : "R7";
      if (dack_i && sb.size() > 0) begin
        exp_t h;
        h = sb[0];
        h.rem--;
        sb[0] = h;
        if (h.rem == 0) begin
          exp_done = 1'b1;
          etag     = h.tag;
          eburst   = h.burst;
          void'(sb.pop_front());
        end
      end
      if (exp_done || done_valid) begin
        chk(rq, "done_valid", done_valid, exp_done);
        if (exp_done && done_valid) begin
          chk("R7", "done_tag", done_tag, etag);
          chk("R7", "done_burst", done_burst, eburst);
          dones_seen++;
        end
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [3:0] b,
                      input logic burst, input logic [TAGW-1:0] tag);
    logic rdy;
    @(negedge clk);
    req_addr  = a;
    req_bytes = b;
    req_burst = burst;
    req_tag   = tag;
    req_valid = 1'b1;
    do begin
      rdy = req_ready;
      @(negedge clk);
    end while (!rdy);
    req_valid = 1'b0;
  endtask

  task automatic addr_ack(input logic [TAGW-1:0] tag, input logic burst);
    for (int i = 0; i < 50 && !abus_valid; i++) @(negedge clk);
    aack_i = 1'b1;
    sb.push_back('{tag: tag, burst: burst, rem: (burst ? 4 : 1)});
    @(negedge clk);
    aack_i = 1'b0;
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin
      dack_i = 1'b1;
      @(negedge clk);
    end
    dack_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "br_o", br_o, 0);
    chk("R1", "abus_valid", abus_valid, 0);
    chk("R1", "done_valid", done_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 parked grant, R3 tenure fields and hold
    bg_i = 1'b1;
    send(32'h1000_0040, 4'd4, 1'b0, 4'd1);
    chk("R5", "abus_valid", abus_valid, 1);
    chk("R5", "br_o", br_o, 0);
    chk("R3", "abus_addr", abus_addr, 32'h1000_0040);
    chk("R3", "abus_bytes", abus_bytes, 4);
    chk("R3", "abus_burst", abus_burst, 0);
    chk("R2", "req_ready during tenure", req_ready, 0);
    repeat (2) @(negedge clk);
    chk("R3", "abus_valid held", abus_valid, 1);
    chk("R3", "abus_addr held", abus_addr, 32'h1000_0040);
    addr_ack(4'd1, 1'b0);
    chk("R3", "abus_valid after aack", abus_valid, 0);
    beats(1);
    chk("R7", "single retires on first beat", dones_seen, 1);

    // R4 request/grant handshake, burst reports 32 bytes
    bg_i = 1'b0;
    send(32'h2000_0000, 4'd8, 1'b1, 4'd2);
    chk("R4", "br_o raised", br_o, 1);
    chk("R4", "abus_valid before grant", abus_valid, 0);
    repeat (3) @(negedge clk);
    chk("R4", "br_o held", br_o, 1);
    bg_i = 1'b1;
    @(negedge clk);
    chk("R4", "abus_valid after grant", abus_valid, 1);
    chk("R4", "br_o after grant", br_o, 0);
    chk("R3", "burst bytes", abus_bytes, 32);
    chk("R3", "burst flag", abus_burst, 1);
    addr_ack(4'd2, 1'b1);
    base = dones_seen;
    beats(3);
    chk("R7", "burst not done after 3 beats", dones_seen, base);
    beats(1);
    chk("R7", "burst done on beat 4", dones_seen, base + 1);

    // R6 two outstanding, R7 order
    send(32'h3000_0000, 4'd2, 1'b0, 4'd3);
    addr_ack(4'd3, 1'b0);
    send(32'h3000_0100, 4'd1, 1'b1, 4'd4);
    addr_ack(4'd4, 1'b1);
    chk("R6", "req_ready full", req_ready, 0);
    bg_i      = 1'b0;
    req_addr  = 32'h3000_0200;
    req_bytes = 4'd8;
    req_burst = 1'b0;
    req_tag   = 4'd5;
    req_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R6", "br_o while full", br_o, 0);
    end
    chk("R2", "abus_valid while full", abus_valid, 0);
    base = dones_seen;
    beats(1);
    chk("R7", "oldest retired", dones_seen, base + 1);
    chk("R6", "req_ready after retire", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4", "br_o for queued request", br_o, 1);
    bg_i = 1'b1;
    @(negedge clk);
    addr_ack(4'd5, 1'b0);
    beats(4);
    beats(1);
    chk("R7", "all three done in order", dones_seen, base + 3);

    // R8 stray data acknowledges
    base = dones_seen;
    beats(3);
    chk("R8", "no done from stray dack", dones_seen, base);
    send(32'h4000_0000, 4'd3, 1'b1, 4'd7);
    addr_ack(4'd7, 1'b1);
    beats(3);
    chk("R8", "beat count untouched", dones_seen, base);
    beats(1);
    chk("R8", "burst done on own 4th beat", dones_seen, base + 1);

    // R9 illegal single size dropped
    base = dones_seen;
    send(32'h5000_0000, 4'd5, 1'b0, 4'd8);
    chk("R9", "abus_valid", abus_valid, 0);
    chk("R9", "br_o", br_o, 0);
    repeat (3) @(negedge clk);
    chk("R9", "req_ready", req_ready, 1);
    chk("R9", "no completion", dones_seen, base);

    // R10 overlap and same-edge aack/dack
    send(32'h6000_0000, 4'd8, 1'b1, 4'd9);
    addr_ack(4'd9, 1'b1);
    beats(1);
    send(32'h6000_1000, 4'd8, 1'b0, 4'd10);
    chk("R10", "tenure while data pending", abus_valid, 1);
    aack_i = 1'b1;
    dack_i = 1'b1;
    sb.push_back('{tag: 4'd10, burst: 1'b0, rem: 1});
    @(negedge clk);
    aack_i = 1'b0;
    dack_i = 1'b0;
    chk("R10", "tenure ended", abus_valid, 0);
    chk("R10", "no early done", dones_seen, base);
    beats(2);
    chk("R10", "burst done after same-edge beat", dones_seen, base + 1);
    beats(1);
    chk("R10", "single done", dones_seen, base + 2);

    repeat (3) @(negedge clk);
    chk("R7", "scoreboard drained", sb.size(), 0);
    summary();
    $finish;
  end

endmodule